// File: doc/BRIEF.md
# Constant-Time Modular Coefficient Adder-Subtractor

This block adds or subtracts two number-theoretic-transform coefficients modulo a prime Q. Q is fixed at build time to 7681 or 12289. Results normally stay in a redundant range that is wider than Q. For Q = 7681 the word is 14 bits; for Q = 12289 it is 15 bits. A redundant result can go straight back in as an operand. When the caller asks for a canonical value, a final borrow-masked correction brings the result into [0, Q-1].

Every operation goes through the same adder, fold and correction stages, whatever the operand values. Timing therefore carries no information about the data.

Subtraction inverts the subtrahend and adds 4Q+1. The intermediate sum can then never go negative. The sum is folded with a fixed shift-and-mask step that uses 2^K mod Q = 2^S - 1. Then, if requested, the value passes through masked "subtract Q, add Q back on borrow" stages.

The input and output are valid/ready streams, with the result registered.

- An operation is accepted when `in_valid` and `in_ready` are both high at a clock edge.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output holds and no new operation is taken.

Top module: `ct_mod_addsub`

## Requirements
- R1: With `in_sub` = 0, the result is congruent to `in_a + in_b` modulo Q, for all operands in [0, 2^W - 1].
- R2: With `in_sub` = 1, the result is congruent to `in_a - in_b` modulo Q, for all operands in [0, 2^W - 1], including `in_b` > `in_a`.
- R3: With `in_full` = 0, the result fits in W bits (W = 14 for Q = 7681, W = 15 for Q = 12289) without wrapping. Feeding each result back as an operand over hundreds of successive additions keeps it congruent to the running sum.
- R4: With `in_full` = 1, the result lies in [0, Q-1] and is congruent as in R1/R2.
- R5: An operation accepted at a clock edge appears on `out_res` with `out_valid` high after exactly that edge. With no accepted operation and `out_ready` high, `out_valid` is low after the next edge.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, `out_valid` stays high and `out_res` is unchanged. The offered operation is taken once `out_ready` returns high.
- R7: After reset, `out_valid` is 0, `out_res` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_a | input | W | First operand, redundant form |
| in_b | input | W | Second operand, redundant form |
| in_sub | input | 1 | 1 = a - b, 0 = a + b |
| in_full | input | 1 | 1 = canonical result in [0, Q-1] |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | W | Result |

## Verification
Both moduli are built side by side and driven with the same stimulus.

A strided grid spans the whole operand range in all four add/subtract × redundant/canonical modes. This shows whether the offset-and-fold path keeps congruence wherever the intermediate sum lands.

A corner set probes where the fold and the correction change behaviour: 0, 1, Q-1, Q, 2Q-1, 2Q and the all-ones word. These values separate a missing second correction stage or a wrong borrow mask from correct reduction.

A feedback chain of repeated additions exposes any drift out of the redundant range. Stall and drain sequences separate correct back-pressure from a register that is overwritten or slips by a cycle.

// File: rtl/cma_pkg.sv
package cma_pkg;

  // Data word width for a supported modulus.
  function automatic int unsigned word_w(input int unsigned q);
    return (q == 12289) ? 15 : 14;
  endfunction

  // Fold split point K: 2^K mod q equals 2^S - 1.
  function automatic int unsigned fold_k(input int unsigned q);
    return (q == 12289) ? 14 : 13;
  endfunction

  function automatic int unsigned fold_s(input int unsigned q);
    return (q == 12289) ? 12 : 9;
  endfunction

  // Masked correction stages needed so a folded word ends below q.
  function automatic int unsigned trim_stages(input int unsigned q);
    return (q == 12289) ? 2 : 1;
  endfunction

endpackage

// File: rtl/cma_presum.sv
module cma_presum #(
  parameter int unsigned Q  = 7681,
  parameter int unsigned W  = 14,
  parameter int unsigned IW = 16
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          sub,
  output logic [IW-1:0] r
);
  // One adder serves both operations. For subtraction, b is inverted and
  // 4Q+1 is added, which gives 4Q + a - b and never goes negative.
  localparam logic [IW-1:0] OFFSET = IW'(4 * Q + 1);

  logic [IW-1:0] b_ext;
  logic [IW-1:0] off;

  always_comb begin
    b_ext = IW'(b) ^ {IW{sub}};
    off   = OFFSET & {IW{sub}};
    r     = IW'(a) + b_ext + off;
  end
endmodule

// File: rtl/cma_fold.sv
module cma_fold #(
  parameter int unsigned IW = 16,
  parameter int unsigned K  = 13,
  parameter int unsigned S  = 9
) (
  input  logic [IW-1:0] r,
  output logic [IW-1:0] f
);
  // The bits above K are worth (2^S - 1) each modulo q, so they are
  // re-added at weight 2^S and subtracted at weight 1.
  logic [IW-1:0] hi;
  logic [IW-1:0] lo;

  always_comb begin
    hi = r >> K;
    lo = IW'(r[K-1:0]);
    f  = lo - hi + (hi << S);
  end
endmodule

// File: rtl/cma_trim.sv
module cma_trim #(
  parameter int unsigned Q = 7681,
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] v,
  input  logic         en,
  output logic [W-1:0] o
);
  // Subtract Q unconditionally. The borrow, or a disabled stage, widens
  // into a mask that adds Q back.
  logic [W:0] diff;
  logic       restore;

  always_comb begin
    diff    = {1'b0, v} - (W + 1)'(Q);
    restore = diff[W] | ~en;
    o       = diff[W-1:0] + (W'(Q) & {W{restore}});
  end
endmodule

// File: rtl/ct_mod_addsub.sv
module ct_mod_addsub #(
  parameter  int unsigned Q = 7681,
  localparam int unsigned W = cma_pkg::word_w(Q)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_sub,
  input  logic         in_full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_res
);
  localparam int unsigned IW = W + 2;
  localparam int unsigned K  = cma_pkg::fold_k(Q);
  localparam int unsigned S  = cma_pkg::fold_s(Q);
  localparam int unsigned NT = cma_pkg::trim_stages(Q);

  logic [IW-1:0] pre_sum;
  logic [IW-1:0] fold_sum;
  logic [W-1:0]  trim_chain [0:NT];

  cma_presum #(.Q(Q), .W(W), .IW(IW)) u_presum (
    .a  (in_a),
    .b  (in_b),
    .sub(in_sub),
    .r  (pre_sum)
  );

  cma_fold #(.IW(IW), .K(K), .S(S)) u_fold (
    .r(pre_sum),
    .f(fold_sum)
  );

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (fold_sum[IW-1:W] == '0));

  assign trim_chain[0] = fold_sum[W-1:0];

  for (genvar g = 0; g < NT; g++) begin : g_trim
    cma_trim #(.Q(Q), .W(W)) u_trim (
      .v (trim_chain[g]),
      .en(in_full),
      .o (trim_chain[g+1])
    );
  end

  // R4
  full_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_full) |-> (trim_chain[NT] < W'(Q)));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= trim_chain[NT];
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  // R1 R2
  congruent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (((int'($past(in_a)) + ($past(in_sub) ? (4 * int'(Q) - int'($past(in_b)))
                                             : int'($past(in_b)))) % int'(Q))
       == (int'(out_res) % int'(Q))));
endmodule

// File: tb/ct_mod_addsub_bench.sv
`timescale 1ns/1ps
module ct_mod_addsub_bench;
  localparam int QL = 7681;
  localparam int QH = 12289;
  localparam int ML = 16383;
  localparam int MH = 32767;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sub = 1'b0, in_full = 1'b0, out_ready = 1'b1;
  logic [13:0] a_lo = '0, b_lo = '0, res_lo;
  logic [14:0] a_hi = '0, b_hi = '0, res_hi;
  logic rdy_lo, rdy_hi, ov_lo, ov_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ct_mod_addsub #(.Q(QL)) u_ct_mod_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_lo),
    .in_a(a_lo), .in_b(b_lo), .in_sub(in_sub), .in_full(in_full),
    .out_valid(ov_lo), .out_ready(out_ready), .out_res(res_lo));

  ct_mod_addsub #(.Q(QH)) u_ct_mod_addsub_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_hi),
    .in_a(a_hi), .in_b(b_hi), .in_sub(in_sub), .in_full(in_full),
    .out_valid(ov_hi), .out_ready(out_ready), .out_res(res_hi));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_mod(input int a, input int b, input bit sub, input int q);
    int e;
    e = sub ? (a - b) % q : (a + b) % q;
    if (e < 0) e += q;
    return e;
  endfunction

  // Called at a falling edge; returns one cycle later at a falling edge.
  task automatic run_op(input int al, input int bl, input int ah, input int bh,
                        input bit sub, input bit full);
    int el, eh;
    a_lo = 14'(al); b_lo = 14'(bl); a_hi = 15'(ah); b_hi = 15'(bh);
    in_sub = sub; in_full = full; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    el = ref_mod(al, bl, sub, QL);
    eh = ref_mod(ah, bh, sub, QH);
    chk(ov_lo && ov_hi, "R5 valid", int'(ov_lo & ov_hi), 1);
    chk(int'(res_lo) % QL == el, sub ? "R2 q7681" : "R1 q7681", int'(res_lo) % QL, el);
    chk(int'(res_hi) % QH == eh, sub ? "R2 q12289" : "R1 q12289", int'(res_hi) % QH, eh);
    if (full) begin
      chk(int'(res_lo) == el, "R4 q7681", int'(res_lo), el);
      chk(int'(res_hi) == eh, "R4 q12289", int'(res_hi), eh);
    end
  endtask

  initial begin
    int corner_lo [7];
    int corner_hi [7];
    int acc_lo, acc_hi;
    int hold_lo, hold_hi;

    corner_lo = '{0, 1, QL - 1, QL, 2 * QL - 1, 2 * QL, ML};
    corner_hi = '{0, 1, QH - 1, QH, 2 * QH - 1, 2 * QH, MH};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7
    chk(!ov_lo && !ov_hi, "R7 out_valid", int'(ov_lo | ov_hi), 0);
    chk(res_lo == 0 && res_hi == 0, "R7 out_res", int'(res_lo) + int'(res_hi), 0);
    chk(rdy_lo && rdy_hi, "R7 in_ready", int'(rdy_lo & rdy_hi), 1);

    // R1 R2 R4: strided sweep over the full operand range, all four modes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          run_op(i * ML / 63, j * ML / 63, i * MH / 63, j * MH / 63, m[0], m[1]);

    // R1 R2 R4: corner operands
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          run_op(corner_lo[i], corner_lo[j], corner_hi[i], corner_hi[j], m[0], m[1]);

    // R3: feedback chain of redundant additions
    acc_lo = 0; acc_hi = 0;
    a_lo = '0; a_hi = '0;
    for (int k = 0; k < 300; k++) begin
      run_op(int'(res_lo), ML, int'(res_hi), MH, 1'b0, 1'b0);
      acc_lo = (acc_lo + ML) % QL;
      acc_hi = (acc_hi + MH) % QH;
      if (k == 0) begin
        acc_lo = (int'(res_lo)) % QL;
        acc_hi = (int'(res_hi)) % QH;
      end
      chk(int'(res_lo) % QL == acc_lo, "R3 q7681 chain", int'(res_lo) % QL, acc_lo);
      chk(int'(res_hi) % QH == acc_hi, "R3 q12289 chain", int'(res_hi) % QH, acc_hi);
    end

    // R5: idle cycle drops out_valid
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!ov_lo && !ov_hi, "R5 idle", int'(ov_lo | ov_hi), 0);

    // R6: stall, then drain
    run_op(5, 6, 5, 6, 1'b0, 1'b1);
    hold_lo = int'(res_lo); hold_hi = int'(res_hi);
    out_ready = 1'b0;
    a_lo = 14'd0; b_lo = 14'd3; a_hi = 15'd0; b_hi = 15'd3;
    in_sub = 1'b1; in_full = 1'b1; in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk(!rdy_lo && !rdy_hi, "R6 in_ready low", int'(rdy_lo | rdy_hi), 0);
      chk(ov_lo && ov_hi, "R6 valid held", int'(ov_lo & ov_hi), 1);
      chk(int'(res_lo) == hold_lo, "R6 q7681 held", int'(res_lo), hold_lo);
      chk(int'(res_hi) == hold_hi, "R6 q12289 held", int'(res_hi), hold_hi);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(int'(res_lo) == QL - 3, "R6 q7681 drained", int'(res_lo), QL - 3);
    chk(int'(res_hi) == QH - 3, "R6 q12289 drained", int'(res_hi), QH - 3);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule